// File: doc/BRIEF.md
# Serial FIFO Interrupt Status Unit

This block sits between a CPU register interface and the bit engine of a byte-oriented serial master. It buffers outgoing bytes in a shallow transmit FIFO and incoming bytes in a shallow receive FIFO. Only one of the two is in use at a time, chosen by the engine's direction signal. It also keeps one 8-bit status word that the CPU reads and clears.

The CPU writes transmit bytes, reads received bytes, and clears status flags by writing zeros into them. The engine takes bytes from the transmit FIFO, puts received bytes into the receive FIFO, reports a missing acknowledge, and signals when the interface is busy. A missing acknowledge raises a stop request back to the engine. Both error conditions are latched as sticky flags.

Status layout: bit 7 busy, bit 6 no-acknowledge, bit 5 receive interrupt, bit 4 transmit interrupt, bits 3:2 fill code, bit 1 access collision, bit 0 transmit overrun.

Top module: `sfifo_stat_unit`

## Requirements
- R1: While reset is asserted, `status` is 8'h00 and both FIFOs are empty (`eng_tx_valid` low).
- R2: `status[3:2]` encodes the occupancy of the FIFO selected by `eng_dir_rx` (1 = receive, 0 = transmit). The code is 2'b00 below 2 bytes, 2'b10 for 2 or 3 bytes and 2'b11 for 4 bytes. The code 2'b01 never appears.
- R3: `status[7]` follows `eng_busy` one clock later. On the edge where it rises, the transmit FIFO is emptied, and a CPU write in that same cycle is dropped. Writes made while it stays high are kept.
- R4: `eng_nack` high at an edge sets `status[6]`. `eng_stop` always equals `status[6]`.
- R5: `cpu_tx_wr` while the transmit FIFO holds 4 bytes sets `status[0]`, and the byte is discarded.
- R6: `cpu_tx_wr` and `cpu_rx_rd` in the same cycle set `status[1]`, and both accesses still take effect.
- R7: `status[5]` is set at every edge where the receive FIFO is not empty. `status[4]` is set at every edge where the transmit FIFO is empty. Both stay set until cleared.
- R8: A status write (`cpu_st_wr`) clears each of bits 6, 5, 4, 1 and 0 whose `cpu_st_wdata` bit is 0. A 1 leaves that flag unchanged. Bits 7, 3 and 2 are not writable.
- R9: If a flag's set condition and its clear by a status write occur in the same cycle, the flag ends up set.
- R10: Both FIFOs are first-in first-out. `eng_tx_data` and `cpu_rx_data` present the oldest byte, and `eng_tx_valid` is high while the transmit FIFO is not empty.
- R11: `eng_rx_push` while the receive FIFO holds 4 bytes is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_tx_wr | input | 1 | CPU writes a transmit byte |
| cpu_tx_data | input | 8 | Transmit byte from the CPU |
| cpu_rx_rd | input | 1 | CPU reads a receive byte |
| cpu_rx_data | output | 8 | Oldest received byte (0 when empty) |
| cpu_st_wr | input | 1 | CPU writes the status word |
| cpu_st_wdata | input | 8 | Status write data (0 clears a flag) |
| status | output | 8 | Status word |
| eng_busy | input | 1 | Engine reports the interface in use |
| eng_dir_rx | input | 1 | Active direction: 1 receive, 0 transmit |
| eng_tx_pop | input | 1 | Engine takes the oldest transmit byte |
| eng_tx_data | output | 8 | Oldest transmit byte (0 when empty) |
| eng_tx_valid | output | 1 | Transmit FIFO not empty |
| eng_rx_push | input | 1 | Engine stores a received byte |
| eng_rx_data | input | 8 | Received byte from the engine |
| eng_nack | input | 1 | Addressed device did not acknowledge |
| eng_stop | output | 1 | Request to the engine to end the transfer |

## Verification
The bench builds the unit with its default parameters: 8-bit data and 4-entry FIFOs. At that depth four pushes fill a FIFO, so each fill band can be reached in a handful of cycles: the low code for a single byte, the half band at two and three bytes, and full at four. The overrun flag, the dropped fifth receive byte and the direction switch of the shared fill code are also reachable from short directed sequences.

// File: rtl/sfst_pkg.sv
package sfst_pkg;

  typedef enum logic [1:0] {
    FILL_LOW  = 2'b00,
    FILL_RSVD = 2'b01,
    FILL_HALF = 2'b10,
    FILL_FULL = 2'b11
  } fill_e;

  // status bit positions
  localparam int unsigned ST_BUSY  = 7;
  localparam int unsigned ST_NACK  = 6;
  localparam int unsigned ST_RXIRQ = 5;
  localparam int unsigned ST_TXIRQ = 4;
  localparam int unsigned ST_ACC   = 1;
  localparam int unsigned ST_OVR   = 0;

  // flags cleared by a zero write
  localparam logic [7:0] W0C_MASK = 8'b0111_0011;

  function automatic fill_e fill_code(input int unsigned occ, input int unsigned depth);
    if (occ >= depth)          return FILL_FULL;
    else if (occ >= depth / 2) return FILL_HALF;
    else                       return FILL_LOW;
  endfunction

endpackage

// File: rtl/sfst_fifo.sv
module sfst_fifo #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 4,
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic          pop,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic [CW-1:0] count
);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, wr_ptr_d;
  logic [AW-1:0] rd_ptr, rd_ptr_d;
  logic [CW-1:0] count_d;
  logic          full, empty, push_ok, pop_ok;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign push_ok = push & ~full & ~clr;
  assign pop_ok  = pop & ~empty & ~clr;

  function automatic logic [AW-1:0] wrap_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_comb begin
    wr_ptr_d = wr_ptr;
    rd_ptr_d = rd_ptr;
    count_d  = count;
    if (clr) begin
      wr_ptr_d = '0;
      rd_ptr_d = '0;
      count_d  = '0;
    end else begin
      if (push_ok) wr_ptr_d = wrap_inc(wr_ptr);
      if (pop_ok)  rd_ptr_d = wrap_inc(rd_ptr);
      if (push_ok && !pop_ok)      count_d = count + CW'(1);
      else if (pop_ok && !push_ok) count_d = count - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      wr_ptr <= wr_ptr_d;
      rd_ptr <= rd_ptr_d;
      count  <= count_d;
    end
  end

  // storage: one clock-enabled register per entry
  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    always_ff @(posedge clk) begin
      if (push_ok && (wr_ptr == AW'(i))) mem[i] <= wdata;
    end
  end

  assign rdata = empty ? '0 : mem[rd_ptr];

endmodule

// File: rtl/sfst_flags.sv
module sfst_flags #(
  parameter int unsigned W    = 8,
  parameter logic [W-1:0] MASK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set,
  input  logic [W-1:0] clr,
  output logic [W-1:0] q
);

  logic [W-1:0] q_d;

  // set dominates clear
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign q_d[i] = MASK[i] & (set[i] | (q[i] & ~clr[i]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_d;
  end

endmodule

// File: rtl/sfst_fill_sel.sv
module sfst_fill_sel
  import sfst_pkg::*;
#(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic [CW-1:0] tx_cnt,
  input  logic [CW-1:0] rx_cnt,
  input  logic          dir_rx,
  output logic [1:0]    fill
);

  logic [CW-1:0] act_cnt;

  assign act_cnt = dir_rx ? rx_cnt : tx_cnt;
  assign fill    = fill_code(int'(act_cnt), DEPTH);

endmodule

// File: rtl/sfifo_stat_unit.sv
module sfifo_stat_unit
  import sfst_pkg::*;
#(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 4,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_tx_wr,
  input  logic [DW-1:0] cpu_tx_data,
  input  logic          cpu_rx_rd,
  output logic [DW-1:0] cpu_rx_data,
  input  logic          cpu_st_wr,
  input  logic [7:0]    cpu_st_wdata,
  output logic [7:0]    status,
  input  logic          eng_busy,
  input  logic          eng_dir_rx,
  input  logic          eng_tx_pop,
  output logic [DW-1:0] eng_tx_data,
  output logic          eng_tx_valid,
  input  logic          eng_rx_push,
  input  logic [DW-1:0] eng_rx_data,
  input  logic          eng_nack,
  output logic          eng_stop
);

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta, rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_i    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_i    <= rst_meta;
    end
  end

  // busy tracking and flush on rise
  logic busy_q, busy_rise;
  assign busy_rise = eng_busy & ~busy_q;

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) busy_q <= 1'b0;
    else        busy_q <= eng_busy;
  end

  // FIFOs
  logic [CW-1:0] tx_cnt, rx_cnt;
  logic          tx_empty, tx_full, rx_empty;

  sfst_fifo #(.DW(DW), .DEPTH(DEPTH)) u_txq (
    .clk   (clk),
    .rst_n (rst_i),
    .clr   (busy_rise),
    .push  (cpu_tx_wr),
    .pop   (eng_tx_pop),
    .wdata (cpu_tx_data),
    .rdata (eng_tx_data),
    .count (tx_cnt)
  );

  sfst_fifo #(.DW(DW), .DEPTH(DEPTH)) u_rxq (
    .clk   (clk),
    .rst_n (rst_i),
    .clr   (1'b0),
    .push  (eng_rx_push),
    .pop   (cpu_rx_rd),
    .wdata (eng_rx_data),
    .rdata (cpu_rx_data),
    .count (rx_cnt)
  );

  assign tx_empty     = (tx_cnt == '0);
  assign tx_full      = (tx_cnt == CW'(DEPTH));
  assign rx_empty     = (rx_cnt == '0);
  assign eng_tx_valid = ~tx_empty;

  // sticky flags
  logic [7:0] flag_set, flag_clr, flag_q;

  always_comb begin
    flag_set           = '0;
    flag_set[ST_NACK]  = eng_nack;
    flag_set[ST_RXIRQ] = ~rx_empty;
    flag_set[ST_TXIRQ] = tx_empty;
    flag_set[ST_ACC]   = cpu_tx_wr & cpu_rx_rd;
    flag_set[ST_OVR]   = cpu_tx_wr & tx_full;
    flag_clr           = cpu_st_wr ? (~cpu_st_wdata & W0C_MASK) : 8'h00;
  end

  sfst_flags #(.W(8), .MASK(W0C_MASK)) u_flags (
    .clk   (clk),
    .rst_n (rst_i),
    .set   (flag_set),
    .clr   (flag_clr),
    .q     (flag_q)
  );

  // shared fill indicator
  logic [1:0] fill;

  sfst_fill_sel #(.DEPTH(DEPTH)) u_fill (
    .tx_cnt (tx_cnt),
    .rx_cnt (rx_cnt),
    .dir_rx (eng_dir_rx),
    .fill   (fill)
  );

  assign status   = flag_q | {busy_q, 3'b000, fill, 2'b00};
  assign eng_stop = flag_q[ST_NACK];

endmodule

// File: rtl/sfst_checker.sv
module sfst_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       cpu_tx_wr,
  input logic       cpu_rx_rd,
  input logic       cpu_st_wr,
  input logic [7:0] cpu_st_wdata,
  input logic       eng_busy,
  input logic       eng_dir_rx,
  input logic       eng_nack,
  input logic       eng_tx_valid,
  input logic       eng_stop,
  input logic [7:0] status
);

  // wait until the internal reset release has settled
  logic [1:0] warm;
  logic       live;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              warm <= 2'd0;
    else if (warm != 2'd3)   warm <= warm + 2'd1;
  end
  assign live = (warm == 2'd3);

  a_r2_no_reserved: assert property (@(posedge clk) disable iff (!live)
    status[3:2] != 2'b01);

  a_r3_flush_on_rise: assert property (@(posedge clk) disable iff (!live)
    (eng_busy && !status[7]) |=> (status[7] && !eng_tx_valid));

  a_r4_nack_sets: assert property (@(posedge clk) disable iff (!live)
    eng_nack |=> (status[6] && eng_stop));

  a_r4_stop_tracks: assert property (@(posedge clk) disable iff (!live)
    eng_stop == status[6]);

  a_r5_overrun: assert property (@(posedge clk) disable iff (!live)
    (cpu_tx_wr && !eng_dir_rx && status[3:2] == 2'b11) |=> status[0]);

  a_r6_collision: assert property (@(posedge clk) disable iff (!live)
    (cpu_tx_wr && cpu_rx_rd) |=> status[1]);

  a_r8_zero_clears: assert property (@(posedge clk) disable iff (!live)
    (cpu_st_wr && !cpu_st_wdata[6] && !eng_nack) |=> !status[6]);

  a_r8_one_keeps: assert property (@(posedge clk) disable iff (!live)
    (cpu_st_wr && cpu_st_wdata[6] && status[6]) |=> status[6]);

  a_r9_set_wins: assert property (@(posedge clk) disable iff (!live)
    (eng_nack && cpu_st_wr && !cpu_st_wdata[6]) |=> status[6]);

endmodule

bind sfifo_stat_unit sfst_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cpu_tx_wr    (cpu_tx_wr),
  .cpu_rx_rd    (cpu_rx_rd),
  .cpu_st_wr    (cpu_st_wr),
  .cpu_st_wdata (cpu_st_wdata),
  .eng_busy     (eng_busy),
  .eng_dir_rx   (eng_dir_rx),
  .eng_nack     (eng_nack),
  .eng_tx_valid (eng_tx_valid),
  .eng_stop     (eng_stop),
  .status       (status)
);

// File: tb/sim_sfifo_stat_unit.sv
`timescale 1ns/1ps
module sim_sfifo_stat_unit;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cpu_tx_wr, cpu_rx_rd, cpu_st_wr;
  logic [7:0] cpu_tx_data, cpu_rx_data, cpu_st_wdata, status;
  logic       eng_busy, eng_dir_rx, eng_tx_pop, eng_tx_valid;
  logic       eng_rx_push, eng_nack, eng_stop;
  logic [7:0] eng_tx_data, eng_rx_data;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  sfifo_stat_unit u0 (
    .clk(clk), .rst_n(rst_n),
    .cpu_tx_wr(cpu_tx_wr), .cpu_tx_data(cpu_tx_data),
    .cpu_rx_rd(cpu_rx_rd), .cpu_rx_data(cpu_rx_data),
    .cpu_st_wr(cpu_st_wr), .cpu_st_wdata(cpu_st_wdata),
    .status(status),
    .eng_busy(eng_busy), .eng_dir_rx(eng_dir_rx),
    .eng_tx_pop(eng_tx_pop), .eng_tx_data(eng_tx_data), .eng_tx_valid(eng_tx_valid),
    .eng_rx_push(eng_rx_push), .eng_rx_data(eng_rx_data),
    .eng_nack(eng_nack), .eng_stop(eng_stop)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic st_write(input logic [7:0] v);
    cpu_st_wr = 1'b1; cpu_st_wdata = v;
    tick();
    cpu_st_wr = 1'b0;
  endtask

  task automatic tx_write(input logic [7:0] v);
    cpu_tx_wr = 1'b1; cpu_tx_data = v;
    tick();
    cpu_tx_wr = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    cpu_tx_wr = 0; cpu_rx_rd = 0; cpu_st_wr = 0;
    cpu_tx_data = 0; cpu_st_wdata = 0;
    eng_busy = 0; eng_dir_rx = 0; eng_tx_pop = 0;
    eng_rx_push = 0; eng_rx_data = 0; eng_nack = 0;
    repeat (3) tick();
    chk("R1", "status in reset", status, 8'h00);
    chk("R1", "tx valid in reset", eng_tx_valid, 1'b0);
    rst_n = 1'b1;
    repeat (4) tick();
    chk("R7", "tx irq after reset", status, 8'h10);
  endtask

  task automatic t_tx_fill();
    logic [1:0] exp_fill [4] = '{2'b00, 2'b10, 2'b10, 2'b11};
    eng_dir_rx = 1'b0;
    for (int i = 0; i < 4; i++) begin
      tx_write(8'hA0 + 8'(i));
      chk("R2", $sformatf("tx fill after %0d", i + 1), status[3:2], exp_fill[i]);
    end
    chk("R10", "tx valid", eng_tx_valid, 1'b1);
    eng_dir_rx = 1'b1;
    #1;
    chk("R2", "fill follows rx side", status[3:2], 2'b00);
    eng_dir_rx = 1'b0;
    #1;
    st_write(8'h00);
    chk("R8", "overrun clear", status[0], 1'b0);
    tx_write(8'hEE);
    chk("R5", "overrun flag", status[0], 1'b1);
    chk("R5", "fill stays full", status[3:2], 2'b11);
    for (int i = 0; i < 4; i++) begin
      chk("R10", $sformatf("tx order %0d", i), eng_tx_data, 8'hA0 + 8'(i));
      eng_tx_pop = 1'b1; tick(); eng_tx_pop = 1'b0;
    end
    chk("R5", "dropped byte absent", eng_tx_valid, 1'b0);
    chk("R2", "tx fill empty", status[3:2], 2'b00);
  endtask

  task automatic t_collision();
    st_write(8'h00);
    chk("R8", "collision clear", status[1], 1'b0);
    cpu_tx_wr = 1'b1; cpu_tx_data = 8'h5A; cpu_rx_rd = 1'b1;
    tick();
    cpu_tx_wr = 1'b0; cpu_rx_rd = 1'b0;
    chk("R6", "collision flag", status[1], 1'b1);
    chk("R6", "write still taken", eng_tx_data, 8'h5A);
    eng_tx_pop = 1'b1; tick(); eng_tx_pop = 1'b0;
    st_write(8'h00);
    chk("R6", "collision cleared", status[1], 1'b0);
  endtask

  task automatic t_nack();
    eng_nack = 1'b1; tick(); eng_nack = 1'b0;
    chk("R4", "nack flag", status[6], 1'b1);
    chk("R4", "stop request", eng_stop, 1'b1);
    st_write(8'hFF);
    chk("R8", "write one keeps nack", status[6], 1'b1);
    chk("R8", "busy not writable", status[7], 1'b0);
    st_write(8'hBF);
    chk("R8", "zero clears nack", status[6], 1'b0);
    chk("R4", "stop drops", eng_stop, 1'b0);
  endtask

  task automatic t_set_wins();
    eng_nack = 1'b1; cpu_st_wr = 1'b1; cpu_st_wdata = 8'h00;
    tick();
    eng_nack = 1'b0; cpu_st_wr = 1'b0;
    chk("R9", "nack set over clear", status[6], 1'b1);
    chk("R9", "tx irq set over clear", status[4], 1'b1);
    st_write(8'h00);
    chk("R8", "nack cleared", status[6], 1'b0);
  endtask

  task automatic t_rx();
    logic [1:0] exp_fill [5] = '{2'b00, 2'b10, 2'b10, 2'b11, 2'b11};
    eng_dir_rx = 1'b1;
    st_write(8'h00);
    chk("R7", "rx irq clear while empty", status[5], 1'b0);
    for (int i = 0; i < 5; i++) begin
      eng_rx_push = 1'b1; eng_rx_data = 8'hC0 + 8'(i);
      tick();
      eng_rx_push = 1'b0;
      chk("R2", $sformatf("rx fill after %0d", i + 1), status[3:2], exp_fill[i]);
    end
    chk("R7", "rx irq", status[5], 1'b1);
    for (int i = 0; i < 4; i++) begin
      chk("R10", $sformatf("rx order %0d", i), cpu_rx_data, 8'hC0 + 8'(i));
      cpu_rx_rd = 1'b1; tick(); cpu_rx_rd = 1'b0;
    end
    chk("R11", "fifth byte dropped", status[3:2], 2'b00);
    chk("R11", "rx data empty", cpu_rx_data, 8'h00);
    st_write(8'h00);
    chk("R7", "rx irq stays clear", status[5], 1'b0);
    chk("R7", "tx irq while tx empty", status[4], 1'b1);
    eng_dir_rx = 1'b0;
  endtask

  task automatic t_busy();
    eng_dir_rx = 1'b0;
    tx_write(8'h11);
    tx_write(8'h22);
    chk("R3", "fill before busy", status[3:2], 2'b10);
    eng_busy = 1'b1;
    tick();
    chk("R3", "busy flag", status[7], 1'b1);
    chk("R3", "tx flushed", eng_tx_valid, 1'b0);
    chk("R3", "fill after flush", status[3:2], 2'b00);
    tx_write(8'h33);
    chk("R3", "write while busy kept", eng_tx_data, 8'h33);
    eng_busy = 1'b0;
    tick();
    chk("R3", "busy drops", status[7], 1'b0);
    eng_tx_pop = 1'b1; tick(); eng_tx_pop = 1'b0;
    chk("R10", "tx empty again", eng_tx_valid, 1'b0);
  endtask

  initial begin
    t_reset();
    t_tx_fill();
    t_collision();
    t_nack();
    t_set_wins();
    t_rx();
    t_busy();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog (all requirements): got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

endmodule